// File: doc/BRIEF.md
# SPI Master with Transmit Readback Check

This block is an 8-bit serial peripheral interface master that a processor drives through three small registers: a control/status register, a data register and a mode register. Software picks the serial clock rate and enables the serial function in the mode register. It then loads a byte into the data register and sets a start bit in the control register. The block shifts the byte out MSB first while it shifts a byte in. Each transaction has a direction bit. A write transaction sends the data register contents to the peripheral. A read transaction holds the output line high and loads the received byte into the data register when the transfer ends.

During a write transaction the block samples a readback copy of the serial output line on every rising clock edge and compares it with the bit it meant to drive. Any difference latches a sticky failure flag. Software reads this flag through the same control bit that starts a transaction, and writing 0 to that bit clears it. At the end of every transaction an interrupt flag is set. Until software acknowledges the flag, the data register is frozen and new starts are refused.

Top module: `spi_verify_master`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x00, `irq` is low, `sck` is low and `mosi` is high.
- R2: Writing address 0 with bit 1 set starts a transaction when the block is enabled, idle and the interrupt flag is clear. Busy (bit 3 of address 0) then reads 1 for exactly 8 × D system clock cycles.
- R3: The divider D is 4, 8, 16 or 32 for baud codes 0, 1, 2 and 3 in mode register (address 2) bits [1:0].
- R4: The serial function is enabled only when mode register bits [3:2] are 10 or 11. Otherwise a start request leaves the block idle.
- R5: `sck` idles low. Data goes out MSB first. `mosi` changes only on falling `sck` edges during a transfer, and `miso` and `mosi_rb` are sampled on rising edges.
- R6: In a write transaction, a rising-edge sample of `mosi_rb` that differs from the bit being sent sets the failure flag, which reads on bit 1 of address 0. The flag stays set across later transactions until it is cleared.
- R7: Writing address 0 with bit 1 at 0 clears the failure flag and leaves the interrupt flag as it was when bit 2 is written 1.
- R8: At the end of every transaction the interrupt flag (bit 2 of address 0, and the `irq` output) is set. Writing 0 to bit 2 clears it.
- R9: Writes to the data register (address 1) are ignored while a transfer runs or while the interrupt flag is set.
- R10: When the direction bit (bit 0 of address 0) is 1, `mosi` stays high, the comparison is disabled, and the received byte is loaded into the data register when the transfer ends.
- R11: A start request made while busy or while the interrupt flag is set is ignored, and so is a direction change made while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control/status, 1 data, 2 mode |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Contents of the selected register (combinational) |
| irq | output | 1 | Interrupt flag |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| mosi_rb | input | 1 | Readback of the serial output line, as seen on the wire |

## Verification
The hardest case to reach from the ports is a readback mismatch on one chosen bit of a write transfer, together with its sticky behaviour across a later clean transfer. The bench model of the wire flips `mosi_rb` on a single, randomly picked bit index, which it tracks by counting `sck` falling edges. It also acknowledges the interrupt in a way that leaves the flag in place before it starts the clean transfer. A directed sequence issues a second start with a different direction partway through a running transfer, which shows that both the request and the direction change are ignored.

// File: rtl/spi_vm_pkg.sv
package spi_vm_pkg;
   typedef enum logic [1:0] {
      ADR_CTRL = 2'd0,
      ADR_DATA = 2'd1,
      ADR_MODE = 2'd2,
      ADR_NONE = 2'd3
   } spi_vm_addr_e;

   // control/status bit positions
   localparam int unsigned CB_DIR  = 0;
   localparam int unsigned CB_GO   = 1;
   localparam int unsigned CB_IRQ  = 2;
   localparam int unsigned CB_BUSY = 3;
endpackage

// File: rtl/spi_vm_clkgen.sv
module spi_vm_clkgen #(
   parameter int BAUD_W   = 2,
   parameter int DIV_BASE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [BAUD_W-1:0] baud,
   output logic              sck,
   output logic              rise,
   output logic              fall
);
   localparam int NRATES   = 1 << BAUD_W;
   localparam int HALF_MAX = (DIV_BASE / 2) << (NRATES - 1);
   localparam int CNT_W    = $clog2(HALF_MAX) + 1;

   generate
      if (DIV_BASE < 2 || (DIV_BASE % 2) != 0) begin : g_bad_div
         $error("spi_vm_clkgen: DIV_BASE must be even and at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] lim_tab [NRATES];
   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   for (genvar g = 0; g < NRATES; g++) begin : g_rate
      assign lim_tab[g] = CNT_W'(((DIV_BASE / 2) << g) - 1);
   end

   assign tick = run && (cnt_q == lim_tab[baud]);
   assign rise = tick && !sck;
   assign fall = tick && sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck   <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         sck   <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         sck   <= !sck;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/spi_vm_shifter.sv
module spi_vm_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dir_rd,
   input  logic         rise,
   input  logic         fall,
   input  logic         miso,
   input  logic         rb,
   input  logic         clr_fail,
   output logic         tx_bit,
   output logic [W-1:0] rx_word,
   output logic         done,
   output logic         fail
);
   localparam int BC_W = $clog2(W);

   generate
      if (W < 2) begin : g_bad_w
         $error("spi_vm_shifter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]    sh_q;
   logic            smp_q;
   logic [BC_W-1:0] bit_q;

   assign tx_bit  = sh_q[W-1];
   assign rx_word = {sh_q[W-2:0], smp_q};
   assign done    = fall && (bit_q == BC_W'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         smp_q <= 1'b0;
         bit_q <= '0;
         fail  <= 1'b0;
      end else begin
         if (load) begin
            sh_q  <= load_val;
            bit_q <= '0;
         end else if (fall) begin
            sh_q  <= {sh_q[W-2:0], smp_q};
            bit_q <= bit_q + 1'b1;
         end
         if (rise) smp_q <= miso;
         if (clr_fail) fail <= 1'b0;
         if (rise && !dir_rd && (rb != sh_q[W-1])) fail <= 1'b1;
      end
   end
endmodule

// File: rtl/spi_verify_master.sv
module spi_verify_master
   import spi_vm_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int BAUD_W   = 2,
   parameter int DIV_BASE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   input  logic              mosi_rb
);
   generate
      if (DATA_W < 4 || DATA_W < BAUD_W + 2) begin : g_bad_width
         $error("spi_verify_master: DATA_W too narrow for register fields");
      end
   endgenerate

   logic              busy_q, irq_q, dir_q;
   logic [DATA_W-1:0] data_q;
   logic [BAUD_W-1:0] baud_q;
   logic [1:0]        psel_q;
   logic              wr_ctrl, wr_dat, wr_mode;
   logic              enabled, start, clr_fail;
   logic              rise, fall, done, fail_w, tx_bit;
   logic [DATA_W-1:0] rx_word;

   assign wr_ctrl  = wr_en && (reg_addr == ADR_CTRL);
   assign wr_dat   = wr_en && (reg_addr == ADR_DATA);
   assign wr_mode  = wr_en && (reg_addr == ADR_MODE);
   assign enabled  = psel_q[1];
   assign start    = wr_ctrl && wr_data[CB_GO] && enabled && !busy_q && !irq_q;
   assign clr_fail = wr_ctrl && !wr_data[CB_GO];

   spi_vm_clkgen #(.BAUD_W(BAUD_W), .DIV_BASE(DIV_BASE)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(busy_q), .baud(baud_q),
      .sck(sck), .rise(rise), .fall(fall)
   );

   spi_vm_shifter #(.W(DATA_W)) u_sh (
      .clk(clk), .rst_n(rst_n), .load(start), .load_val(data_q),
      .dir_rd(dir_q), .rise(rise), .fall(fall), .miso(miso), .rb(mosi_rb),
      .clr_fail(clr_fail), .tx_bit(tx_bit), .rx_word(rx_word),
      .done(done), .fail(fail_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         irq_q  <= 1'b0;
         dir_q  <= 1'b0;
         data_q <= '0;
         baud_q <= '0;
         psel_q <= '0;
      end else begin
         if (wr_mode) begin
            baud_q <= wr_data[BAUD_W-1:0];
            psel_q <= wr_data[BAUD_W+1:BAUD_W];
         end
         if (wr_ctrl) begin
            if (!busy_q) dir_q <= wr_data[CB_DIR];
            if (!wr_data[CB_IRQ]) irq_q <= 1'b0;
         end
         if (wr_dat && !busy_q && !irq_q) data_q <= wr_data;
         if (start) busy_q <= 1'b1;
         if (done) begin
            busy_q <= 1'b0;
            irq_q  <= 1'b1;
            if (dir_q) data_q <= rx_word;
         end
      end
   end

   assign irq  = irq_q;
   assign mosi = (busy_q && !dir_q) ? tx_bit : 1'b1;

   always_comb begin
      rd_data = '0;
      case (reg_addr)
         ADR_CTRL: begin
            rd_data[CB_DIR]  = dir_q;
            rd_data[CB_GO]   = fail_w;
            rd_data[CB_IRQ]  = irq_q;
            rd_data[CB_BUSY] = busy_q;
         end
         ADR_DATA: rd_data = data_q;
         ADR_MODE: rd_data[BAUD_W+1:0] = {psel_q, baud_q};
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/spi_vm_checker.sv
module spi_vm_checker #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         busy_i,
   input logic         irq_i,
   input logic         dir_i,
   input logic         fail_i,
   input logic         sck_i,
   input logic         mosi_i,
   input logic [W-1:0] data_i,
   input logic         wr_i,
   input logic [1:0]   addr_i,
   input logic [W-1:0] wdata_i
);
   p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_i |-> !sck_i);

   p_mosi_moves_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && $past(busy_i) && !$fell(sck_i)) |-> $stable(mosi_i));

   p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_i && !(wr_i && addr_i == 2'd0 && !wdata_i[1])) |=> fail_i);

   p_irq_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_i) |-> irq_i);

   p_data_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i |=> $stable(data_i));

   p_read_line_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && dir_i) |-> mosi_i);

   p_no_start_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_i) |-> !$past(irq_i));

   p_dir_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && $past(busy_i)) |-> $stable(dir_i));
endmodule

bind spi_verify_master spi_vm_checker #(.W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy_i(busy_q), .irq_i(irq_q), .dir_i(dir_q),
   .fail_i(fail_w), .sck_i(sck), .mosi_i(mosi), .data_i(data_q),
   .wr_i(wr_en), .addr_i(reg_addr), .wdata_i(wr_data)
);

// File: tb/sim_spi_verify_master.sv
`timescale 1ns/1ps
module sim_spi_verify_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       irq, sck, mosi, miso, mosi_rb;

   int         n_run = 0, n_fail = 0;
   logic [7:0] slv_sh = 8'h00;
   logic [7:0] cap = 8'h00;
   int         bit_i = 0;
   logic       inj_en = 1'b0;
   int         inj_bit = 0;
   logic       fail_model = 1'b0;

   always #10 clk = ~clk;

   spi_verify_master u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .sck(sck),
      .mosi(mosi), .miso(miso), .mosi_rb(mosi_rb)
   );

   // peripheral and wire model
   assign miso    = slv_sh[7];
   assign mosi_rb = mosi ^ (inj_en && (bit_i == inj_bit));
   always @(posedge sck) cap = {cap[6:0], mosi};
   always @(negedge sck) begin
      slv_sh = {slv_sh[6:0], 1'b0};
      bit_i  = bit_i + 1;
   end

   function automatic int exp_cycles(input int baud);
      return 8 * (4 << baud);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_addr = a; wr_data = d;
      if (a == 2'd0 && !d[1]) fail_model = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      reg_addr = a;
      #1 v = rd_data;
   endtask

   task automatic run_xfer(input int baud, input logic dir, input logic [7:0] tx,
                           input logic [7:0] slv, input logic inj, input int ib,
                           input logic pre_clear, input logic [1:0] ps,
                           input int restart_at);
      logic [7:0] v;
      int n;
      if (pre_clear) wr(2'd0, 8'h00);
      wr(2'd2, {4'b0, ps, 2'(baud)});
      wr(2'd1, tx);
      slv_sh = slv; bit_i = 0; inj_en = inj; inj_bit = ib; cap = 8'h00;
      wr(2'd0, 8'h06 | {7'b0, dir});
      n = 0;
      forever begin
         if (n == restart_at) begin
            wr_en = 1'b1; wr_data = {7'b0000011, !dir};
         end else begin
            wr_en = 1'b0;
         end
         rd(2'd0, v);
         if (!v[3] || n > 2000) break;
         n++;
         @(negedge clk);
      end
      wr_en = 1'b0;
      if (!dir && inj) fail_model = 1'b1;
      check(restart_at >= 0 ? "R11 restart ignored" : "R2/R3 busy length", n, exp_cycles(baud));
      rd(2'd0, v);
      check("R8 irq bit set", v[2], 1);
      check("R8 irq port set", irq, 1);
      check("R6 failure flag", v[1], fail_model);
      check("R11 direction kept", v[0], dir);
      check("R5 bits on wire", cap, dir ? 8'hFF : tx);
      rd(2'd1, v);
      check(dir ? "R10 received byte" : "R9 tx data kept", v, dir ? slv : tx);
      wr(2'd1, ~v);
      rd(2'd1, v);
      check("R9 data frozen while irq", v, dir ? slv : tx);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rd(2'd0, v);
      check("R1 ctrl reset", v, 8'h00);
      check("R1 irq reset", irq, 0);
      check("R1 sck reset", sck, 0);
      check("R1 mosi reset", mosi, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: port select 01 keeps the block idle
      wr(2'd2, 8'h04);
      wr(2'd0, 8'h06);
      repeat (4) @(negedge clk);
      rd(2'd0, v);
      check("R4 disabled start busy", v[3], 0);
      check("R4 disabled start irq", v[2], 0);

      // directed: every baud code, clean write then read
      for (int b = 0; b < 4; b++) begin
         run_xfer(b, 1'b0, 8'hA5 ^ 8'(b), 8'h3C, 1'b0, 0, 1'b1, 2'b10, -1);
         run_xfer(b, 1'b1, 8'h00, 8'hC3 ^ 8'(b), 1'b1, b, 1'b1, 2'b11, -1);
      end

      // R11: start refused while irq still set
      wr(2'd0, 8'h06);
      @(negedge clk);
      rd(2'd0, v);
      check("R11 start with irq set", v[3], 0);

      // R6 sticky: corrupt bit 0 (MSB), ack keeping fail, clean transfer
      run_xfer(0, 1'b0, 8'h81, 8'h00, 1'b1, 0, 1'b1, 2'b10, -1);
      wr(2'd0, 8'h02);
      rd(2'd0, v);
      check("R6 fail kept after ack", v[1], 1);
      run_xfer(1, 1'b0, 8'h5A, 8'h00, 1'b0, 0, 1'b0, 2'b10, -1);
      // R7: clear fail, keep irq
      wr(2'd0, 8'h04);
      rd(2'd0, v);
      check("R7 fail cleared", v[1], 0);
      check("R7 irq kept", v[2], 1);
      wr(2'd0, 8'h00);
      rd(2'd0, v);
      check("R8 irq cleared", v[2], 0);

      // R11: restart with other direction mid-transfer
      run_xfer(0, 1'b0, 8'h96, 8'h11, 1'b0, 0, 1'b1, 2'b10, 3);

      // random transfers
      for (int k = 0; k < 24; k++) begin
         int b = $urandom_range(0, 3);
         logic d = 1'($urandom_range(0, 1));
         logic j = 1'($urandom_range(0, 1));
         run_xfer(b, d, 8'($urandom), 8'($urandom), j, $urandom_range(0, 7),
                  1'b1, 2'($urandom_range(2, 3)), -1);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule